// File: doc/BRIEF.md
# Three-Register Bank with Status Flags

This block is the storage stage of a small sequential processor. It holds three data registers of a parameterised width (five bits by default), called A, B and C here, plus two single-bit status flags: an overflow flag and a greater-or-equal flag. Every element has its own load strobe. All registers and flags share one synchronous clear strobe, and also a synchronous active-low reset.

Data arrives on two buses. The memory bus carries immediate operands fetched from program storage. The datapath bus carries arithmetic results. The two datapath flag bits arrive alongside the datapath bus. Register A always loads from the memory bus, and register C always loads from the datapath bus. Register B is the only register with a choice of source: it takes either the memory bus or the current contents of register C. Each flag loads from its own datapath flag bit.

The block does not decode instructions and does not compute anything. It samples its inputs on the rising clock edge and presents every stored value on its outputs.

Top module: `regbank_core`

## Requirements
- R1: While `rst_n` is low at a rising edge, all three registers and both flags become zero after that edge.
- R2: When `clr` is high at a rising edge, all registers and flags become zero after that edge, whatever the load strobes are.
- R3: With `clr` low and `ld_a` high, `reg_a` takes the value of `mem_data` sampled at that edge.
- R4: With `clr` low, `ld_b` high and `b_from_c` = 0, `reg_b` takes the value of `mem_data`.
- R5: With `clr` low, `ld_b` high and `b_from_c` = 1, `reg_b` takes the value `reg_c` held before the edge. This holds even when `ld_c` loads a new value into C at the same edge.
- R6: With `clr` low and `ld_c` high, `reg_c` takes the value of `dp_result`.
- R7: With `clr` low and `ld_ovf` high, `ovf_flag` takes `dp_ovf`. With `clr` low and `ld_ge` high, `ge_flag` takes `dp_ge`.
- R8: With `clr` low, every register or flag whose load strobe is low keeps its value. When `ld_b` is low, `b_from_c` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| clr | input | 1 | Synchronous clear of every register and flag |
| mem_data | input | DW | Operand bus from program memory |
| dp_result | input | DW | Result bus from the datapath |
| dp_ovf | input | 1 | Overflow bit from the datapath |
| dp_ge | input | 1 | Greater-or-equal bit from the datapath |
| ld_a | input | 1 | Load strobe for register A |
| ld_b | input | 1 | Load strobe for register B |
| b_from_c | input | 1 | Source of register B: 0 memory bus, 1 register C |
| ld_c | input | 1 | Load strobe for register C |
| ld_ovf | input | 1 | Load strobe for the overflow flag |
| ld_ge | input | 1 | Load strobe for the greater-or-equal flag |
| reg_a | output | DW | Contents of register A |
| reg_b | output | DW | Contents of register B |
| reg_c | output | DW | Contents of register C |
| ovf_flag | output | 1 | Overflow flag |
| ge_flag | output | 1 | Greater-or-equal flag |

## Verification
The assertions check on every cycle the relation between each strobe and the next value of its register or flag. This covers reset, clear priority, loads from each source, holding, and the use of the pre-edge value of C by register B.

Some cases depend on particular timing combinations, and only the bench scenarios can show them. Examples are C and B loading at the same edge, clear arriving with every strobe raised, and a source select toggled while B's strobe is low. The bench also runs a long random stretch in which a behavioural model is compared against the outputs on every clock.

// File: rtl/regbank_pkg.sv
// Shared definitions for the register bank.
// Assumes: data width is set by the top module parameter.
package regbank_pkg;

    // Source choice for register B.
    typedef enum logic {
        B_SRC_MEM = 1'b0,
        B_SRC_REGC = 1'b1
    } b_src_e;

    // Index of each flag in the packed flag vector.
    localparam int FLAG_OVF = 0;
    localparam int FLAG_GE = 1;
    localparam int NUM_FLAGS = 2;

endpackage

// File: rtl/rb_cell.sv
// One storage element of parameterised width.
// Priority order: reset, then clear, then load. Without a load the value holds.
// Assumes: rst_n and clr are synchronous to clk.
module rb_cell #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    // Update the stored value under reset, clear and load priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (clr) begin
            q <= '0;
        end else if (en) begin
            q <= d;
        end
    end

endmodule

// File: rtl/rb_bsrc_mux.sv
// Source selector for register B: picks the memory bus or the current value of register C.
// Assumes: the select line is already decoded to the b_src_e encoding.
module rb_bsrc_mux
    import regbank_pkg::*;
#(
    parameter int W = 5
) (
    input  b_src_e       sel,
    input  logic [W-1:0] mem_in,
    input  logic [W-1:0] regc_in,
    output logic [W-1:0] y
);

    // Choose the load value for register B.
    always_comb begin
        unique case (sel)
            B_SRC_REGC: y = regc_in;
            default:    y = mem_in;
        endcase
    end

endmodule

// File: rtl/regbank_core.sv
// Register bank: three data registers and two flags, each with its own load strobe,
// plus a shared synchronous clear and a synchronous active-low reset.
// Assumes: all inputs are synchronous to clk. Register B reads C's pre-edge value.
module regbank_core
    import regbank_pkg::*;
#(
    parameter int DW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [DW-1:0] mem_data,
    input  logic [DW-1:0] dp_result,
    input  logic          dp_ovf,
    input  logic          dp_ge,
    input  logic          ld_a,
    input  logic          ld_b,
    input  logic          b_from_c,
    input  logic          ld_c,
    input  logic          ld_ovf,
    input  logic          ld_ge,
    output logic [DW-1:0] reg_a,
    output logic [DW-1:0] reg_b,
    output logic [DW-1:0] reg_c,
    output logic          ovf_flag,
    output logic          ge_flag
);

    logic [DW-1:0]        b_next;
    logic [NUM_FLAGS-1:0] flag_d;
    logic [NUM_FLAGS-1:0] flag_en;
    logic [NUM_FLAGS-1:0] flag_q;
    b_src_e               b_sel;

    // Map the raw select bit onto the typed source encoding.
    assign b_sel = b_src_e'(b_from_c);

    // Collect the flag inputs and strobes into vectors indexed by flag.
    always_comb begin
        flag_d           = '0;
        flag_en          = '0;
        flag_d[FLAG_OVF] = dp_ovf;
        flag_d[FLAG_GE]  = dp_ge;
        flag_en[FLAG_OVF] = ld_ovf;
        flag_en[FLAG_GE]  = ld_ge;
    end

    rb_bsrc_mux #(.W(DW)) u_bmux (
        .sel     (b_sel),
        .mem_in  (mem_data),
        .regc_in (reg_c),
        .y       (b_next)
    );

    rb_cell #(.W(DW)) u_rega (
        .clk (clk), .rst_n (rst_n), .clr (clr),
        .en  (ld_a), .d (mem_data), .q (reg_a)
    );

    rb_cell #(.W(DW)) u_regb (
        .clk (clk), .rst_n (rst_n), .clr (clr),
        .en  (ld_b), .d (b_next), .q (reg_b)
    );

    rb_cell #(.W(DW)) u_regc (
        .clk (clk), .rst_n (rst_n), .clr (clr),
        .en  (ld_c), .d (dp_result), .q (reg_c)
    );

    // One single-bit cell per flag.
    for (genvar gi = 0; gi < NUM_FLAGS; gi++) begin : g_flag
        rb_cell #(.W(1)) u_flag (
            .clk (clk), .rst_n (rst_n), .clr (clr),
            .en  (flag_en[gi]), .d (flag_d[gi]), .q (flag_q[gi])
        );
    end

    assign ovf_flag = flag_q[FLAG_OVF];
    assign ge_flag  = flag_q[FLAG_GE];

endmodule

// File: rtl/regbank_chk.sv
// Property checker for regbank_core. It observes ports only and is attached by bind.
module regbank_chk #(
    parameter int DW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          clr,
    input logic [DW-1:0] mem_data,
    input logic [DW-1:0] dp_result,
    input logic          dp_ovf,
    input logic          dp_ge,
    input logic          ld_a,
    input logic          ld_b,
    input logic          b_from_c,
    input logic          ld_c,
    input logic          ld_ovf,
    input logic          ld_ge,
    input logic [DW-1:0] reg_a,
    input logic [DW-1:0] reg_b,
    input logic [DW-1:0] reg_c,
    input logic          ovf_flag,
    input logic          ge_flag
);

    AST_RESET_ZERO: assert property (@(posedge clk)
        !rst_n |=> (reg_a == '0 && reg_b == '0 && reg_c == '0 && !ovf_flag && !ge_flag)); // R1

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (reg_a == '0 && reg_b == '0 && reg_c == '0 && !ovf_flag && !ge_flag)); // R2

    AST_A_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && ld_a) |=> reg_a == $past(mem_data)); // R3

    AST_B_FROM_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && ld_b && !b_from_c) |=> reg_b == $past(mem_data)); // R4

    AST_B_FROM_C: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && ld_b && b_from_c) |=> reg_b == $past(reg_c)); // R5

    AST_C_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && ld_c) |=> reg_c == $past(dp_result)); // R6

    AST_OVF_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && ld_ovf) |=> ovf_flag == $past(dp_ovf)); // R7

    AST_GE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && ld_ge) |=> ge_flag == $past(dp_ge)); // R7

    AST_A_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !ld_a) |=> $stable(reg_a)); // R8

    AST_B_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !ld_b) |=> $stable(reg_b)); // R8

    AST_C_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !ld_c) |=> $stable(reg_c)); // R8

    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !ld_ovf && !ld_ge) |=> ($stable(ovf_flag) && $stable(ge_flag))); // R8

endmodule

bind regbank_core regbank_chk #(.DW(DW)) u_chk (
    .clk (clk), .rst_n (rst_n), .clr (clr),
    .mem_data (mem_data), .dp_result (dp_result), .dp_ovf (dp_ovf), .dp_ge (dp_ge),
    .ld_a (ld_a), .ld_b (ld_b), .b_from_c (b_from_c), .ld_c (ld_c),
    .ld_ovf (ld_ovf), .ld_ge (ld_ge),
    .reg_a (reg_a), .reg_b (reg_b), .reg_c (reg_c),
    .ovf_flag (ovf_flag), .ge_flag (ge_flag)
);

// File: tb/sim_regbank_core.sv
// Bench: a behavioural model, updated from the applied stimulus, is compared with every output on every clock.
module sim_regbank_core;

    localparam int DW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clr = 1'b0;
    logic [DW-1:0] mem_data = '0;
    logic [DW-1:0] dp_result = '0;
    logic          dp_ovf = 1'b0;
    logic          dp_ge = 1'b0;
    logic          ld_a = 1'b0;
    logic          ld_b = 1'b0;
    logic          b_from_c = 1'b0;
    logic          ld_c = 1'b0;
    logic          ld_ovf = 1'b0;
    logic          ld_ge = 1'b0;
    logic [DW-1:0] reg_a, reg_b, reg_c;
    logic          ovf_flag, ge_flag;

    int  n_checks = 0;
    int  n_fails = 0;
    bit  done = 1'b0;

    // Model state and the requirement tag attached to each output for the next compare.
    int    m_a = 0, m_b = 0, m_c = 0, m_ovf = 0, m_ge = 0;
    string t_a = "R1", t_b = "R1", t_c = "R1", t_ovf = "R1", t_ge = "R1";

    always #5 clk = ~clk;

    regbank_core #(.DW(DW)) u0 (
        .clk (clk), .rst_n (rst_n), .clr (clr),
        .mem_data (mem_data), .dp_result (dp_result), .dp_ovf (dp_ovf), .dp_ge (dp_ge),
        .ld_a (ld_a), .ld_b (ld_b), .b_from_c (b_from_c), .ld_c (ld_c),
        .ld_ovf (ld_ovf), .ld_ge (ld_ge),
        .reg_a (reg_a), .reg_b (reg_b), .reg_c (reg_c),
        .ovf_flag (ovf_flag), .ge_flag (ge_flag)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Compare all outputs with the model (called at a falling edge).
    task automatic compare_all();
        check(t_a, "reg_a", int'(reg_a), m_a);
        check(t_b, "reg_b", int'(reg_b), m_b);
        check(t_c, "reg_c", int'(reg_c), m_c);
        check(t_ovf, "ovf_flag", int'(ovf_flag), m_ovf);
        check(t_ge, "ge_flag", int'(ge_flag), m_ge);
    endtask

    // Drive one cycle of stimulus and advance the model to the post-edge state.
    task automatic step(input bit rn, input bit cl, input int md, input int dr,
                        input bit ov, input bit ge, input bit la, input bit lb,
                        input bit bs, input bit lc, input bit lo, input bit lg);
        int old_c;
        rst_n = rn; clr = cl; mem_data = md[DW-1:0]; dp_result = dr[DW-1:0];
        dp_ovf = ov; dp_ge = ge; ld_a = la; ld_b = lb; b_from_c = bs;
        ld_c = lc; ld_ovf = lo; ld_ge = lg;
        old_c = m_c;
        if (!rn) begin
            m_a = 0; m_b = 0; m_c = 0; m_ovf = 0; m_ge = 0;
            t_a = "R1"; t_b = "R1"; t_c = "R1"; t_ovf = "R1"; t_ge = "R1";
        end else if (cl) begin
            m_a = 0; m_b = 0; m_c = 0; m_ovf = 0; m_ge = 0;
            t_a = "R2"; t_b = "R2"; t_c = "R2"; t_ovf = "R2"; t_ge = "R2";
        end else begin
            if (la) begin m_a = md % (1 << DW); t_a = "R3"; end else t_a = "R8";
            if (lb) begin
                m_b = bs ? old_c : md % (1 << DW);
                t_b = bs ? "R5" : "R4";
            end else t_b = "R8";
            if (lc) begin m_c = dr % (1 << DW); t_c = "R6"; end else t_c = "R8";
            if (lo) begin m_ovf = ov; t_ovf = "R7"; end else t_ovf = "R8";
            if (lg) begin m_ge = ge; t_ge = "R7"; end else t_ge = "R8";
        end
        @(negedge clk);
        compare_all();
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  %0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1: reset state
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        // R3 / R4 / R6 / R7: single loads from each source
        step(1, 0, 9, 0, 0, 0, 1, 0, 0, 0, 0, 0);
        step(1, 0, 3, 0, 0, 0, 0, 1, 0, 0, 0, 0);
        step(1, 0, 0, 12, 1, 0, 0, 0, 0, 1, 1, 0);
        step(1, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 1);
        // R5: B loads C's old value while C loads a new one
        step(1, 0, 31, 21, 0, 0, 0, 1, 1, 1, 0, 0);
        // R8: select toggled with B's strobe low; every strobe low
        step(1, 0, 7, 2, 0, 0, 0, 0, 1, 0, 0, 0);
        step(1, 0, 17, 30, 0, 0, 0, 0, 0, 0, 0, 0);
        // R2: clear overrides every strobe
        step(1, 1, 31, 31, 1, 1, 1, 1, 0, 1, 1, 1);
        // Load all at once, then B from C with the maximum value
        step(1, 0, 31, 31, 1, 1, 1, 1, 0, 1, 1, 1);
        step(1, 0, 0, 0, 0, 0, 0, 1, 1, 0, 0, 0);
        // R1: reset overrides strobes
        step(0, 0, 5, 5, 1, 1, 1, 1, 0, 1, 1, 1);
        // Random stretch
        for (int i = 0; i < 400; i++) begin
            step(($urandom % 32) != 0, ($urandom % 10) == 0,
                 int'($urandom % 32), int'($urandom % 32),
                 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
        end
        done = 1'b1;
        $display("  %0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

endmodule